// File: doc/BRIEF.md
# One-Time Fuse Burn Sequencer

This controller drives a one-time-programmable fuse array that holds four data blocks and is reached through a register-style command port. It writes a configuration key, issues a command and polls the command register until it reads zero. After a start pulse it goes through the blocks from the highest index down to block 0. Block 0 is last because it carries protection bits for the other blocks. A block whose staged words are all zero is skipped. For every other block the controller keeps its own backup copy of the staged words, clears the array's program registers and then loads them. It then runs a program step and a read step and compares the readback with the backup.

A readback mismatch starts a retry, and so does a coding error that was not present before the burn. Each retry clears the program registers and reloads them from the backup, and a block gets at most three attempts. A block that still mismatches after its last attempt sets the fail status. Every lower block after it is then skipped. A coding error that is still there after the last attempt only raises a warning. A command that never completes sets the fail status and ends the run.

Top module: `fuse_burn_seq`

## Requirements
- R1: Burn attempts go through the blocks in strictly descending index order (3, 2, 1, 0), and block index is shown on `blkSel` while a command is issued.
- R2: A block whose staged words are all zero gets no program-register write and no command.
- R3: After a block ends with a readback mismatch on its final attempt, `fail` is 1 and no lower-index block gets a program command.
- R4: The program step writes 0x5A5A to the configuration register, issues command code 2 on the next cycle, and waits until `cmdRdata` reads zero.
- R5: The read step writes 0x5AA5 to the configuration register, issues command code 1 on the next cycle, and waits until `cmdRdata` reads zero before the readback is compared.
- R6: A block gets at most 3 program commands. Before each one, all of the block's program words are first written with zero and then written with the staged words that were captured before the first attempt, so the controller does not rely on program registers that the array has overwritten.
- R7: A new coding error also causes a retry. A coding error for block b≥1 is the OR of `decWarn[4(b-1)+3:4(b-1)]`, and it counts as new only when that value was 0 before the block's first attempt and is 1 after a read step. Block 0 never has a coding error.
- R8: `fail` is set only by a mismatch on the final attempt or by a command timeout. A new coding error that is still present after the final attempt sets only `warn`.
- R9: A `start` pulse while idle clears `fail` and `warn` and raises `busy` on the next cycle. `done` is a one-cycle pulse at the end of the run, and `busy` is low in the following cycle.
- R10: If `cmdRdata` stays nonzero for more than TIMEOUT cycles, `fail` is set, no further command is issued and `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run while idle |
| stageData | input | NB*WPB*WW | Staged write words, block b word w at bits [(b*WPB+w)*WW +: WW] |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Overall failure status |
| warn | output | 1 | Unresolved coding error warning |
| cfgWe | output | 1 | Configuration register write strobe |
| cfgData | output | 16 | Configuration key |
| cmdWe | output | 1 | Command register write strobe |
| cmdData | output | 2 | Command code: 2 program, 1 read |
| cmdRdata | input | 2 | Command register readback, zero when idle |
| progWe | output | 1 | Program register write strobe |
| blkSel | output | BW | Block addressed by program, command and readback |
| wordIdx | output | IW | Word addressed in program registers and readback |
| progData | output | WW | Program register write data |
| rdData | input | WW | Readback word for `blkSel`/`wordIdx` |
| decWarn | input | 4*(NB-1) | Decode warning nibbles for blocks 1 and up |

## Verification
The retry decision looks at two things in the same cycle: the accumulated readback mismatch and the new-coding-error test. Both can be true for the same attempt. The fuse model in the bench can corrupt the readback and raise a block's warning nibble on the same program completion, and random scenarios also produce this overlap. The expected attempt count, `fail` and `warn` are worked out from the rule that either cause triggers a retry, while the outcome of the final attempt sends a mismatch to `fail` and a coding error to `warn`. A warning that was already present before the burn combined with a corrupted readback tests that only the mismatch counts in that case.

// File: rtl/fuse_burn_pkg.sv
package fuse_burn_pkg;
  localparam logic [15:0] CFG_PGM = 16'h5A5A;
  localparam logic [15:0] CFG_RD  = 16'h5AA5;
  localparam logic [1:0]  CMD_PGM = 2'h2;
  localparam logic [1:0]  CMD_RD  = 2'h1;

  typedef enum logic [3:0] {
    S_IDLE, S_SELECT, S_CLEAR, S_LOAD, S_PCFG, S_PCMD, S_PWAIT,
    S_RCFG, S_RCMD, S_RWAIT, S_CHECK, S_DECIDE, S_NEXT, S_FINISH
  } seqState_t;

  typedef struct packed {
    logic initRun;
    logic loadBlk;
    logic idxClr;
    logic idxInc;
    logic toutClr;
    logic toutInc;
    logic toutFail;
    logic mismClr;
    logic cmpEn;
    logic retry;
    logic commit;
    logic blkDec;
    logic loadPhase;
  } strobe_t;
endpackage

// File: rtl/fuse_burn_ctrl.sv
module fuse_burn_ctrl
  import fuse_burn_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        stageZero,
  input  logic        failedAny,
  input  logic        lastWord,
  input  logic        cmdIdle,
  input  logic        timedOut,
  input  logic        badAttempt,
  input  logic        triesLeft,
  input  logic        blkIsZero,
  output strobe_t     st,
  output logic        busy,
  output logic        done,
  output logic        cfgWe,
  output logic [15:0] cfgData,
  output logic        cmdWe,
  output logic [1:0]  cmdData,
  output logic        progWe
);
  seqState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FINISH);

  always_comb begin
    st      = '0;
    nxt     = state;
    cfgWe   = 1'b0;
    cfgData = '0;
    cmdWe   = 1'b0;
    cmdData = '0;
    progWe  = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        st.initRun = 1'b1;
        nxt = S_SELECT;
      end
      S_SELECT: begin
        if (failedAny || stageZero) nxt = S_NEXT;
        else begin
          st.loadBlk = 1'b1;
          st.idxClr  = 1'b1;
          nxt = S_CLEAR;
        end
      end
      S_CLEAR: begin
        progWe = 1'b1;
        if (lastWord) begin st.idxClr = 1'b1; nxt = S_LOAD; end
        else st.idxInc = 1'b1;
      end
      S_LOAD: begin
        progWe = 1'b1;
        st.loadPhase = 1'b1;
        if (lastWord) begin st.idxClr = 1'b1; nxt = S_PCFG; end
        else st.idxInc = 1'b1;
      end
      S_PCFG: begin
        cfgWe = 1'b1; cfgData = CFG_PGM; nxt = S_PCMD;
      end
      S_PCMD: begin
        cmdWe = 1'b1; cmdData = CMD_PGM; st.toutClr = 1'b1; nxt = S_PWAIT;
      end
      S_PWAIT: begin
        if (cmdIdle) nxt = S_RCFG;
        else if (timedOut) begin st.toutFail = 1'b1; nxt = S_FINISH; end
        else st.toutInc = 1'b1;
      end
      S_RCFG: begin
        cfgWe = 1'b1; cfgData = CFG_RD; nxt = S_RCMD;
      end
      S_RCMD: begin
        cmdWe = 1'b1; cmdData = CMD_RD; st.toutClr = 1'b1; nxt = S_RWAIT;
      end
      S_RWAIT: begin
        if (cmdIdle) begin
          st.idxClr = 1'b1; st.mismClr = 1'b1; nxt = S_CHECK;
        end else if (timedOut) begin st.toutFail = 1'b1; nxt = S_FINISH; end
        else st.toutInc = 1'b1;
      end
      S_CHECK: begin
        st.cmpEn = 1'b1;
        if (lastWord) nxt = S_DECIDE;
        else st.idxInc = 1'b1;
      end
      S_DECIDE: begin
        if (badAttempt && triesLeft) begin
          st.retry = 1'b1; st.idxClr = 1'b1; nxt = S_CLEAR;
        end else begin
          st.commit = 1'b1; nxt = S_NEXT;
        end
      end
      S_NEXT: begin
        if (blkIsZero) nxt = S_FINISH;
        else begin st.blkDec = 1'b1; nxt = S_SELECT; end
      end
      S_FINISH: nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end
endmodule

// File: rtl/fuse_burn_dp.sv
module fuse_burn_dp
  import fuse_burn_pkg::*;
#(
  parameter int NB        = 4,
  parameter int WPB       = 4,
  parameter int WW        = 8,
  parameter int MAX_TRIES = 3,
  parameter int TIMEOUT   = 64,
  localparam int BW  = $clog2(NB),
  localparam int IW  = $clog2(WPB),
  localparam int AW  = $clog2(MAX_TRIES + 1),
  localparam int TW  = $clog2(TIMEOUT + 1),
  localparam int BLK_BITS = WPB * WW
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              st,
  input  logic [NB*BLK_BITS-1:0] stageData,
  input  logic [WW-1:0]        rdData,
  input  logic [4*(NB-1)-1:0]  decWarn,
  input  logic [1:0]           cmdRdata,
  output logic                 stageZero,
  output logic                 failedAny,
  output logic                 lastWord,
  output logic                 cmdIdle,
  output logic                 timedOut,
  output logic                 badAttempt,
  output logic                 triesLeft,
  output logic                 blkIsZero,
  output logic [BW-1:0]        blkSel,
  output logic [IW-1:0]        wordIdx,
  output logic [WW-1:0]        progData,
  output logic                 warnAny
);
  logic [BW-1:0]  blk;
  logic [IW-1:0]  idx;
  logic [AW-1:0]  attempt;
  logic [TW-1:0]  toutCnt;
  logic           mism, errBefore, curErr, newErr;
  logic [WW-1:0]  backup [WPB];
  logic [BLK_BITS-1:0] curStage;

  assign curStage  = stageData[blk*BLK_BITS +: BLK_BITS];
  assign stageZero = (curStage == '0);
  assign lastWord  = (idx == IW'(WPB - 1));
  assign cmdIdle   = (cmdRdata == 2'b00);
  assign timedOut  = (toutCnt >= TW'(TIMEOUT));
  assign triesLeft = (attempt < AW'(MAX_TRIES));
  assign blkIsZero = (blk == '0);
  assign blkSel    = blk;
  assign wordIdx   = idx;
  assign progData  = st.loadPhase ? backup[idx] : '0;

  // coding error of the current block: OR of its decode nibble, none for block 0
  always_comb begin
    curErr = 1'b0;
    for (int b = 1; b < NB; b++) begin
      if (blk == BW'(b)) curErr = |decWarn[4*(b-1) +: 4];
    end
  end

  assign newErr     = curErr & ~errBefore;
  assign badAttempt = mism | newErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blk       <= '0;
      idx       <= '0;
      attempt   <= '0;
      toutCnt   <= '0;
      mism      <= 1'b0;
      errBefore <= 1'b0;
      failedAny <= 1'b0;
      warnAny   <= 1'b0;
    end else begin
      if (st.initRun) begin
        blk       <= BW'(NB - 1);
        failedAny <= 1'b0;
        warnAny   <= 1'b0;
      end
      if (st.blkDec) blk <= blk - 1'b1;
      if (st.loadBlk) begin
        attempt   <= AW'(1);
        errBefore <= curErr;
      end
      if (st.retry) attempt <= attempt + 1'b1;
      if (st.idxClr)      idx <= '0;
      else if (st.idxInc) idx <= idx + 1'b1;
      if (st.toutClr)      toutCnt <= '0;
      else if (st.toutInc) toutCnt <= toutCnt + 1'b1;
      if (st.mismClr)                         mism <= 1'b0;
      else if (st.cmpEn && rdData != backup[idx]) mism <= 1'b1;
      if (st.toutFail) failedAny <= 1'b1;
      if (st.commit) begin
        if (mism)   failedAny <= 1'b1;
        if (newErr) warnAny   <= 1'b1;
      end
    end
  end

  for (genvar w = 0; w < WPB; w++) begin : g_backup
    always_ff @(posedge clk) begin
      if (!rstN)           backup[w] <= '0;
      else if (st.loadBlk) backup[w] <= curStage[w*WW +: WW];
    end
  end
endmodule

// File: rtl/fuse_burn_seq.sv
module fuse_burn_seq
  import fuse_burn_pkg::*;
#(
  parameter int NB        = 4,
  parameter int WPB       = 4,
  parameter int WW        = 8,
  parameter int MAX_TRIES = 3,
  parameter int TIMEOUT   = 64,
  localparam int BW = $clog2(NB),
  localparam int IW = $clog2(WPB)
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [NB*WPB*WW-1:0]   stageData,
  output logic                   busy,
  output logic                   done,
  output logic                   fail,
  output logic                   warn,
  output logic                   cfgWe,
  output logic [15:0]            cfgData,
  output logic                   cmdWe,
  output logic [1:0]             cmdData,
  input  logic [1:0]             cmdRdata,
  output logic                   progWe,
  output logic [BW-1:0]          blkSel,
  output logic [IW-1:0]          wordIdx,
  output logic [WW-1:0]          progData,
  input  logic [WW-1:0]          rdData,
  input  logic [4*(NB-1)-1:0]    decWarn
);
  strobe_t st;
  logic stageZero, failedAny, lastWord, cmdIdle, timedOut;
  logic badAttempt, triesLeft, blkIsZero;

  fuse_burn_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .stageZero(stageZero), .failedAny(failedAny), .lastWord(lastWord),
    .cmdIdle(cmdIdle), .timedOut(timedOut), .badAttempt(badAttempt),
    .triesLeft(triesLeft), .blkIsZero(blkIsZero),
    .st(st), .busy(busy), .done(done),
    .cfgWe(cfgWe), .cfgData(cfgData), .cmdWe(cmdWe), .cmdData(cmdData),
    .progWe(progWe)
  );

  fuse_burn_dp #(
    .NB(NB), .WPB(WPB), .WW(WW), .MAX_TRIES(MAX_TRIES), .TIMEOUT(TIMEOUT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .stageData(stageData),
    .rdData(rdData), .decWarn(decWarn), .cmdRdata(cmdRdata),
    .stageZero(stageZero), .failedAny(failedAny), .lastWord(lastWord),
    .cmdIdle(cmdIdle), .timedOut(timedOut), .badAttempt(badAttempt),
    .triesLeft(triesLeft), .blkIsZero(blkIsZero),
    .blkSel(blkSel), .wordIdx(wordIdx), .progData(progData),
    .warnAny(warn)
  );

  assign fail = failedAny;
endmodule

// File: rtl/fuse_burn_chk.sv
module fuse_burn_chk
  import fuse_burn_pkg::*;
#(
  parameter int NB        = 4,
  parameter int MAX_TRIES = 3,
  localparam int BW = $clog2(NB)
)(
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          cfgWe,
  input logic [15:0]   cfgData,
  input logic          cmdWe,
  input logic [1:0]    cmdData,
  input logic          progWe,
  input logic [BW-1:0] blkSel
);
  logic          seenPgm;
  logic [BW-1:0] lastPgm;
  logic [7:0]    pgmCnt;
  logic          pgmCmd;

  assign pgmCmd = cmdWe && (cmdData == CMD_PGM);

  always_ff @(posedge clk) begin
    if (!rstN || (start && !busy)) begin
      seenPgm <= 1'b0;
      lastPgm <= '0;
      pgmCnt  <= '0;
    end else if (pgmCmd) begin
      seenPgm <= 1'b1;
      lastPgm <= blkSel;
      pgmCnt  <= (seenPgm && blkSel == lastPgm) ? pgmCnt + 1'b1 : 8'd1;
    end
  end

  // R4
  pgm_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    pgmCmd |-> ($past(cfgWe) && $past(cfgData) == CFG_PGM));
  // R5
  rd_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWe && cmdData == CMD_RD) |-> ($past(cfgWe) && $past(cfgData) == CFG_RD));
  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cfgWe, cmdWe, progWe}));
  // R9
  done_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!busy && !done));
  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  // R1
  descend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pgmCmd && seenPgm) |-> (blkSel <= lastPgm));
  // R6
  tries_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pgmCmd && seenPgm && blkSel == lastPgm) |-> (pgmCnt < 8'(MAX_TRIES)));
endmodule

bind fuse_burn_seq fuse_burn_chk #(.NB(NB), .MAX_TRIES(MAX_TRIES)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .cfgWe(cfgWe), .cfgData(cfgData), .cmdWe(cmdWe), .cmdData(cmdData),
  .progWe(progWe), .blkSel(blkSel)
);

// File: tb/fuse_burn_seq_tb_top.sv
`timescale 1ns/1ps
module fuse_burn_seq_tb_top;
  localparam int NB = 4, WPB = 4, WW = 8;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [NB*WPB*WW-1:0] stageData = '0;
  logic busy, done, fail, warn, cfgWe, cmdWe, progWe;
  logic [15:0] cfgData;
  logic [1:0] cmdData, cmdRdata;
  logic [1:0] blkSel, wordIdx;
  logic [WW-1:0] progData, rdData;
  logic [4*(NB-1)-1:0] decWarn;

  always #2 clk = ~clk;

  fuse_burn_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .stageData(stageData),
    .busy(busy), .done(done), .fail(fail), .warn(warn),
    .cfgWe(cfgWe), .cfgData(cfgData), .cmdWe(cmdWe), .cmdData(cmdData),
    .cmdRdata(cmdRdata), .progWe(progWe), .blkSel(blkSel), .wordIdx(wordIdx),
    .progData(progData), .rdData(rdData), .decWarn(decWarn)
  );

  int checks = 0, errors = 0, mChecks = 0, mErrors = 0;
  int bad [NB], code [NB], pre [NB];
  bit stuck = 1'b0, mdlClr = 1'b0;

  // fuse array model
  logic [WW-1:0] progReg [NB][WPB];
  logic [WW-1:0] burned  [NB][WPB];
  int att [NB];
  bit trans [NB];
  int busyCnt = 0, wrCnt = 0, logN = 0;
  int logBlk [64];
  logic [1:0] cmdCode = '0, curBlk = '0;

  function automatic logic [WW-1:0] stw(int b, int w);
    return stageData[(b*WPB+w)*WW +: WW];
  endfunction

  assign cmdRdata = (busyCnt != 0) ? cmdCode : 2'b00;
  assign rdData   = burned[blkSel][wordIdx];
  always_comb begin
    for (int b = 1; b < NB; b++)
      decWarn[4*(b-1) +: 4] = pre[b] != 0 ? 4'h3 : (trans[b] ? 4'h8 : 4'h0);
  end

  always @(posedge clk) begin
    if (mdlClr) begin
      busyCnt = 0; wrCnt = 0; logN = 0;
      for (int b = 0; b < NB; b++) begin
        att[b] = 0; trans[b] <= 1'b0;
        for (int w = 0; w < WPB; w++) begin burned[b][w] <= '0; progReg[b][w] <= 8'h3C; end
      end
    end else begin
      if (progWe) begin
        mChecks++;
        if (wrCnt < WPB && progData != 0) begin
          mErrors++;
          $display("FAIL R6 clear phase write: actual %0h expected 0", progData);
        end
        progReg[blkSel][wordIdx] <= progData;
        wrCnt++;
      end
      if (cmdWe) begin
        cmdCode <= cmdData;
        busyCnt = 1 + int'($urandom % 6);
        if (cmdData == 2'h2) begin
          mChecks++;
          if (wrCnt != 2*WPB) begin
            mErrors++;
            $display("FAIL R6 program writes before command: actual %0d expected %0d", wrCnt, 2*WPB);
          end
          for (int w = 0; w < WPB; w++) if (progReg[blkSel][w] != stw(blkSel, w)) begin
            mErrors++;
            $display("FAIL R6 restored word %0d: actual %0h expected %0h", w, progReg[blkSel][w], stw(blkSel, w));
          end
          if (logN < 64) logBlk[logN] = blkSel;
          logN++;
          att[blkSel] = att[blkSel] + 1;
          curBlk <= blkSel;
          wrCnt = 0;
        end
      end else if (busyCnt != 0 && !stuck) begin
        if (busyCnt == 1 && cmdCode == 2'h2) begin
          for (int w = 0; w < WPB; w++) begin
            burned[curBlk][w] <= progReg[curBlk][w] ^ ((att[curBlk] <= bad[curBlk]) ? 8'h01 : 8'h00);
            progReg[curBlk][w] <= 8'hA5;
          end
          trans[curBlk] <= (att[curBlk] <= code[curBlk]);
        end
        busyCnt = busyCnt - 1;
      end
    end
  end

  task automatic chk(bit ok, string msg, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic runScen();
    int expSeq [64];
    int expN = 0, n = 0;
    bit fl = 0, wn = 0, mm, cn, zero;
    mdlClr = 1'b1; @(negedge clk); mdlClr = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(busy == 1'b1 && fail == 0 && warn == 0, "R9 busy and cleared status after start", busy, 1);
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R9 R10 done pulse reached", done, 1);
    // expected outcome from the requirements
    for (int b = NB-1; b >= 0; b--) begin
      zero = 1'b1;
      for (int w = 0; w < WPB; w++) if (stw(b, w) != 0) zero = 1'b0;
      if (fl || zero) continue;                 // R2 R3
      if (stuck) begin expSeq[expN] = b; expN++; fl = 1; break; end   // R10
      for (int a = 1; a <= 3; a++) begin        // R6 R7
        expSeq[expN] = b; expN++;
        mm = (a <= bad[b]);
        cn = (b != 0) && (pre[b] == 0) && (a <= code[b]);
        if (!(mm || cn) || a == 3) begin
          if (mm) fl = 1;                         // R8
          if (cn) wn = 1;
          break;
        end
      end
    end
    chk(logN == expN, "R1 R2 R3 R6 R7 program command count", logN, expN);
    for (int i = 0; i < expN && i < logN; i++)
      chk(logBlk[i] == expSeq[i], "R1 R2 R3 program command block order", logBlk[i], expSeq[i]);
    @(negedge clk);
    chk(fail == fl, "R3 R8 R10 fail status", fail, fl);
    chk(warn == wn, "R8 warn status", warn, wn);
    chk(busy == 0 && done == 0, "R9 idle after done", busy, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic setAll(int bd, int cd, int pr);
    for (int b = 0; b < NB; b++) begin bad[b] = bd; code[b] = cd; pre[b] = (b == 0) ? 0 : pr; end
  endtask

  task automatic fillStage(int zeroMask);
    for (int b = 0; b < NB; b++)
      for (int w = 0; w < WPB; w++)
        stageData[(b*WPB+w)*WW +: WW] = zeroMask[b] ? 8'h00 : 8'(1 + ($urandom % 255));
  endtask

  initial begin
    void'($urandom(32'd2024));
    setAll(0, 0, 0);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && fail == 0 && warn == 0 && cmdWe == 0, "R9 reset state", busy, 0);
    // R1 R4 R5 clean burn of every block
    fillStage(0); runScen();
    // R2 blocks 2 and 0 staged zero
    fillStage(4'b0101); runScen();
    // R6 two bad attempts then success on block 3
    fillStage(0); setAll(0, 0, 0); bad[3] = 2; runScen();
    // R3 block 2 fails every attempt, lower blocks skipped
    setAll(0, 0, 0); bad[2] = 3; runScen();
    // R7 new coding error on first attempt of block 1
    setAll(0, 0, 0); code[1] = 1; runScen();
    // R7 R8 pre-existing error never retries; persistent new error warns only
    setAll(0, 0, 0); pre[2] = 1; code[2] = 3; code[3] = 3; runScen();
    // R7 block 0 coding request has no effect
    setAll(0, 0, 0); code[0] = 3; runScen();
    // mismatch and new coding error in the same attempt, both persisting
    setAll(0, 0, 0); bad[1] = 3; code[1] = 3; runScen();
    // mismatch with pre-existing coding flag
    setAll(0, 0, 0); bad[3] = 3; pre[3] = 1; runScen();
    // R10 command never completes
    setAll(0, 0, 0); stuck = 1'b1; fillStage(4'b1000); runScen();
    stuck = 1'b0;
    // all blocks zero
    fillStage(4'b1111); runScen();
    // random scenarios
    for (int r = 0; r < 40; r++) begin
      fillStage(int'($urandom % 16) & ((($urandom % 3) == 0) ? 15 : 0));
      for (int b = 0; b < NB; b++) begin
        bad[b]  = int'($urandom % 5);
        code[b] = int'($urandom % 4);
        pre[b]  = (b != 0 && ($urandom % 4) == 0) ? 1 : 0;
      end
      runScen();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks + mChecks, errors + mErrors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks + mChecks + 1, errors + mErrors + 1);
    $finish;
  end
endmodule